// File: doc/BRIEF.md
# Programmable static memory bus controller

This block turns single requests from an internal port into timed accesses on an external parallel static-memory bus. The bus has four active-low chip selects, an active-low read strobe, an active-low write strobe, an address bus, and a data bus with a separate output enable. A requester holds `reqValid` with the direction, chip-select index, address and write data until `reqDone` pulses. For a read, `rspData` carries the captured word in that same cycle.

Each chip select has its own timing set, supplied on static configuration inputs. The set holds an encoded setup and pulse count for each of four strobes (write enable, chip select on write, read enable, chip select on read), and an encoded total length for writes and for reads. Hold is whatever remains of the total length after setup and pulse. A mode bit for each chip select and direction picks the controlling strobe: the chip select, or the dedicated enable. The controlling strobe decides when write data is driven and when read data is sampled. Before an access starts, the block checks the configuration. A zero pulse, or a total length shorter than setup plus pulse, refuses the access.

Top module: `smc_bus_ctrl`

## Requirements
- R1: After reset, and while no access is running, every chip select, `memRdN` and `memWeN` are high, `memDataOe` is low and `reqDone` is low.
- R2: A strobe's setup field is 6 bits and decodes to 128·bit5 + bits[4:0] cycles. The strobe first goes low in access cycle t equal to that count, so a setup of 0 means low from t = 0. Access cycle t = 0 is the cycle after the accepting clock edge.
- R3: A strobe's pulse field is 7 bits and decodes to 256·bit6 + bits[5:0] cycles. The strobe stays low for exactly that many consecutive cycles.
- R4: A total-length field is 9 bits and decodes to 256·bits[8:7] + bits[6:0] cycles. An accepted access occupies cycles t = 0 to length−1. `reqDone` is then high for exactly one cycle, with `reqErr` low.
- R5: On a write to chip select c, `memWeN` follows the write-enable timing and `memCsN[c]` follows the chip-select-on-write timing. `memRdN` stays high and the other chip selects stay high. Configuration layout: setup of strobe i of select c is `cfgSetup[(c*4+i)*6 +: 6]`, and pulse is `cfgPulse[(c*4+i)*7 +: 7]`, with i = 0 write enable, 1 chip select on write, 2 read enable, 3 chip select on read. Length is `cfgCycle[(c*2+d)*9 +: 9]`, with d = 0 write and d = 1 read.
- R6: On a read, `memRdN` follows the read-enable timing and `memCsN[c]` follows the chip-select-on-read timing. `memWeN` stays high.
- R7: `memAddr` equals the request address in every cycle of an accepted access.
- R8: On a write, `memDataOe` rises in the cycle where the controlling strobe's setup ends. It stays high through the strobe's pulse and the hold, up to the end of the total length. `memDataOut` equals the write data while it is high. The controlling strobe is the chip select when `cfgWrUsesCs[c]` is 1 and the write enable when it is 0.
- R9: A read samples `memDataIn` on the clock edge that ends the last pulse cycle of the controlling read strobe. The sample is presented on `rspData` when `reqDone` pulses. The controlling strobe is the chip select when `cfgRdUsesCs[c]` is 1 and the read enable when it is 0.
- R10: If either strobe used by the access's direction has a pulse that decodes to 0, the access is refused. In that case `reqDone` and `reqErr` are high together in the cycle after acceptance, and no strobe, chip select or output enable becomes active.
- R11: If the total length is smaller than setup plus pulse of either strobe used by the direction, the access is refused in the same way. A length exactly equal to setup plus pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present, held until reqDone |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCs | input | 2 | Chip-select index |
| reqAddr | input | 12 | Access address |
| reqWdata | input | 16 | Write data |
| reqDone | output | 1 | One-cycle completion pulse |
| reqErr | output | 1 | Set with reqDone when the access was refused |
| rspData | output | 16 | Captured read data |
| cfgSetup | input | 96 | Setup fields, 6 bits per strobe per select |
| cfgPulse | input | 112 | Pulse fields, 7 bits per strobe per select |
| cfgCycle | input | 72 | Total length fields, write then read per select |
| cfgWrUsesCs | input | 4 | Per select: write controlled by chip select |
| cfgRdUsesCs | input | 4 | Per select: read controlled by chip select |
| memCsN | output | 4 | Active-low chip selects |
| memRdN | output | 1 | Active-low read enable |
| memWeN | output | 1 | Active-low write enable |
| memAddr | output | 12 | Address bus |
| memDataOut | output | 16 | Data bus, driven value |
| memDataOe | output | 1 | Data bus output enable |
| memDataIn | input | 16 | Data bus, sampled value |

## Verification
Each chip select is tried with a short timing set and a long one, under all four combinations of the two mode bits, for both directions. The short set has a zero setup and an idle hold. The long set exercises the high offset bits of the setup, pulse and length fields. Comparing every bus signal in every cycle against arithmetic windows separates a mis-decoded field from a swapped strobe index. The bench memory returns valid data only while the controlling strobe is low, so a capture at the wrong edge or under the wrong mode returns a poison word. Refusal runs cover a zero pulse, a length one cycle short and a length exactly at the limit.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int SETUP_W = 6;
  localparam int PULSE_W = 7;
  localparam int CYC_W   = 9;
  localparam int NSTR    = 4;
  localparam int CW      = 10;

  localparam int STR_WE   = 0;
  localparam int STR_CSWR = 1;
  localparam int STR_RD   = 2;
  localparam int STR_CSRD = 3;

  typedef struct packed {
    logic load;
    logic addrEn;
    logic dataOe;
    logic capture;
  } smcCtl_t;

  function automatic logic [CW-1:0] decSetup(input logic [SETUP_W-1:0] f);
    return (CW'(f[5]) << 7) + CW'(f[4:0]);
  endfunction

  function automatic logic [CW-1:0] decPulse(input logic [PULSE_W-1:0] f);
    return (CW'(f[6]) << 8) + CW'(f[5:0]);
  endfunction

  function automatic logic [CW-1:0] decCycle(input logic [CYC_W-1:0] f);
    return (CW'(f[8:7]) << 8) + CW'(f[6:0]);
  endfunction
endpackage

// File: rtl/smc_datapath.sv
module smc_datapath
  import smc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  smcCtl_t       ctl,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] memDataIn,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDataOut,
  output logic          memDataOe,
  output logic [DW-1:0] rspData
);
  logic [AW-1:0] addrR;
  logic [DW-1:0] wdataR;
  logic [DW-1:0] rdataR;
  logic          wrR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      wdataR <= '0;
      wrR    <= 1'b0;
    end else if (ctl.load) begin
      addrR  <= reqAddr;
      wdataR <= reqWdata;
      wrR    <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataR <= '0;
    else if (ctl.capture) rdataR <= memDataIn;
  end

  assign memAddr    = ctl.addrEn ? addrR : '0;
  assign memDataOut = ctl.dataOe ? wdataR : '0;
  assign memDataOe  = ctl.dataOe;
  assign rspData    = rdataR;

  assert_oe_only_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> wrR);
  assert_capture_only_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !wrR);
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrEn && $past(ctl.addrEn)) |-> $stable(memAddr));
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CSW = $clog2(NCS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [CSW-1:0]               reqCs,
  input  logic [NCS*NSTR*SETUP_W-1:0]  cfgSetup,
  input  logic [NCS*NSTR*PULSE_W-1:0]  cfgPulse,
  input  logic [NCS*2*CYC_W-1:0]       cfgCycle,
  input  logic [NCS-1:0]               cfgWrUsesCs,
  input  logic [NCS-1:0]               cfgRdUsesCs,
  output logic                         reqDone,
  output logic                         reqErr,
  output logic [NCS-1:0]               memCsN,
  output logic                         memRdN,
  output logic                         memWeN,
  output smcCtl_t                      ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH, ST_REFUSE} state_t;
  state_t state;

  logic [CW-1:0] cnt, cycR, sDedR, eDedR, sCsR, eCsR;
  logic [CSW-1:0] csR;
  logic wrR, useCsR;

  // decode of the incoming request's timing set
  logic [CW-1:0] sDed, pDed, sCs, pCs, cyc;
  logic useCs, cfgBad;
  always_comb begin
    int dedIdx, csIdx, c;
    c      = int'(reqCs);
    dedIdx = reqWrite ? STR_WE : STR_RD;
    csIdx  = reqWrite ? STR_CSWR : STR_CSRD;
    sDed   = decSetup(cfgSetup[(c*NSTR + dedIdx)*SETUP_W +: SETUP_W]);
    sCs    = decSetup(cfgSetup[(c*NSTR + csIdx)*SETUP_W +: SETUP_W]);
    pDed   = decPulse(cfgPulse[(c*NSTR + dedIdx)*PULSE_W +: PULSE_W]);
    pCs    = decPulse(cfgPulse[(c*NSTR + csIdx)*PULSE_W +: PULSE_W]);
    cyc    = decCycle(cfgCycle[(c*2 + (reqWrite ? 0 : 1))*CYC_W +: CYC_W]);
    useCs  = reqWrite ? cfgWrUsesCs[reqCs] : cfgRdUsesCs[reqCs];
    cfgBad = (pDed == '0) || (pCs == '0) ||
             (cyc < sDed + pDed) || (cyc < sCs + pCs);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cycR   <= '0;
      sDedR  <= '0;
      eDedR  <= '0;
      sCsR   <= '0;
      eCsR   <= '0;
      csR    <= '0;
      wrR    <= 1'b0;
      useCsR <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          cnt    <= '0;
          cycR   <= cyc;
          sDedR  <= sDed;
          eDedR  <= sDed + pDed;
          sCsR   <= sCs;
          eCsR   <= sCs + pCs;
          csR    <= reqCs;
          wrR    <= reqWrite;
          useCsR <= useCs;
          state  <= cfgBad ? ST_REFUSE : ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == cycR - 1'b1) state <= ST_FINISH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic running, dedAct, csAct;
  logic [CW-1:0] ctrlStart, ctrlEnd;
  assign running   = (state == ST_RUN);
  assign dedAct    = running && (cnt >= sDedR) && (cnt < eDedR);
  assign csAct     = running && (cnt >= sCsR) && (cnt < eCsR);
  assign ctrlStart = useCsR ? sCsR : sDedR;
  assign ctrlEnd   = useCsR ? eCsR : eDedR;

  assign memWeN  = !(dedAct && wrR);
  assign memRdN  = !(dedAct && !wrR);
  assign reqDone = (state == ST_FINISH) || (state == ST_REFUSE);
  assign reqErr  = (state == ST_REFUSE);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign memCsN[i] = !(csAct && (csR == CSW'(i)));
  end

  assign ctl.load    = (state == ST_IDLE) && reqValid;
  assign ctl.addrEn  = running;
  assign ctl.dataOe  = running && wrR && (cnt >= ctrlStart);
  assign ctl.capture = running && !wrR && (cnt == ctrlEnd - 1'b1);

  assert_one_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));
  assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWeN));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);
  assert_refuse_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (&memCsN && memRdN && memWeN && !ctl.dataOe));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (&memCsN && memRdN && memWeN));
endmodule

// File: rtl/smc_bus_ctrl.sv
module smc_bus_ctrl
  import smc_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 12,
  parameter int DW  = 16,
  localparam int CSW = $clog2(NCS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [CSW-1:0]               reqCs,
  input  logic [AW-1:0]                reqAddr,
  input  logic [DW-1:0]                reqWdata,
  output logic                         reqDone,
  output logic                         reqErr,
  output logic [DW-1:0]                rspData,
  input  logic [NCS*NSTR*SETUP_W-1:0]  cfgSetup,
  input  logic [NCS*NSTR*PULSE_W-1:0]  cfgPulse,
  input  logic [NCS*2*CYC_W-1:0]       cfgCycle,
  input  logic [NCS-1:0]               cfgWrUsesCs,
  input  logic [NCS-1:0]               cfgRdUsesCs,
  output logic [NCS-1:0]               memCsN,
  output logic                         memRdN,
  output logic                         memWeN,
  output logic [AW-1:0]                memAddr,
  output logic [DW-1:0]                memDataOut,
  output logic                         memDataOe,
  input  logic [DW-1:0]                memDataIn
);
  smcCtl_t ctl;

  smc_ctrl #(.NCS(NCS)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCs(reqCs), .cfgSetup(cfgSetup), .cfgPulse(cfgPulse),
    .cfgCycle(cfgCycle), .cfgWrUsesCs(cfgWrUsesCs), .cfgRdUsesCs(cfgRdUsesCs),
    .reqDone(reqDone), .reqErr(reqErr), .memCsN(memCsN), .memRdN(memRdN),
    .memWeN(memWeN), .ctl(ctl)
  );

  smc_datapath #(.AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDataIn(memDataIn),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .rspData(rspData)
  );
endmodule

// File: tb/smc_bus_ctrl_tb_top.sv
module smc_bus_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] POISON = 16'hDEAD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqCs = '0;
  logic [11:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqDone, reqErr, memRdN, memWeN, memDataOe;
  logic [15:0] rspData, memDataOut, memDataIn;
  logic [3:0] memCsN;
  logic [11:0] memAddr;
  logic [95:0] cfgSetup = '0;
  logic [111:0] cfgPulse = '0;
  logic [71:0] cfgCycle = '0;
  logic [3:0] cfgWrUsesCs = '0, cfgRdUsesCs = '0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int curCs = 0;
  bit curUseCs = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] patt(input logic [11:0] a);
    return 16'hA5C3 ^ {4'h0, a};
  endfunction

  // bench memory: valid data only while the controlling read strobe is low
  assign memDataIn = (curUseCs ? !memCsN[curCs] : !memRdN) ? patt(memAddr) : POISON;

  smc_bus_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqDone(reqDone),
    .reqErr(reqErr), .rspData(rspData), .cfgSetup(cfgSetup),
    .cfgPulse(cfgPulse), .cfgCycle(cfgCycle), .cfgWrUsesCs(cfgWrUsesCs),
    .cfgRdUsesCs(cfgRdUsesCs), .memCsN(memCsN), .memRdN(memRdN),
    .memWeN(memWeN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({memCsN, memWeN, memRdN, memDataOe, reqDone} == 8'b11111100, tag,
        "idle bus", {memCsN, memWeN, memRdN, memDataOe, reqDone}, 8'b11111100);
  endtask

  task automatic setCfg(input int cs,
                        input logic [5:0] s0, s1, s2, s3,
                        input logic [6:0] p0, p1, p2, p3,
                        input logic [8:0] cw, cr, input bit mw, mr);
    cfgSetup[(cs*4+0)*6 +: 6] = s0; cfgSetup[(cs*4+1)*6 +: 6] = s1;
    cfgSetup[(cs*4+2)*6 +: 6] = s2; cfgSetup[(cs*4+3)*6 +: 6] = s3;
    cfgPulse[(cs*4+0)*7 +: 7] = p0; cfgPulse[(cs*4+1)*7 +: 7] = p1;
    cfgPulse[(cs*4+2)*7 +: 7] = p2; cfgPulse[(cs*4+3)*7 +: 7] = p3;
    cfgCycle[(cs*2+0)*9 +: 9] = cw; cfgCycle[(cs*2+1)*9 +: 9] = cr;
    cfgWrUsesCs[cs] = mw; cfgRdUsesCs[cs] = mr;
  endtask

  function automatic int effS(input int cs, input int i);
    logic [5:0] f = cfgSetup[(cs*4+i)*6 +: 6];
    return 128*int'(f[5]) + int'(f[4:0]);
  endfunction
  function automatic int effP(input int cs, input int i);
    logic [6:0] f = cfgPulse[(cs*4+i)*7 +: 7];
    return 256*int'(f[6]) + int'(f[5:0]);
  endfunction
  function automatic int effC(input int cs, input int d);
    logic [8:0] f = cfgCycle[(cs*2+d)*9 +: 9];
    return 256*int'(f[8:7]) + int'(f[6:0]);
  endfunction

  task automatic access(input int cs, input bit wr, input logic [11:0] addr,
                        input logic [15:0] wd);
    int sD, pD, sC, pC, cyc, sCtl, eCtl;
    bit useCs, bad;
    string tagDir;
    sD = effS(cs, wr ? 0 : 2); pD = effP(cs, wr ? 0 : 2);
    sC = effS(cs, wr ? 1 : 3); pC = effP(cs, wr ? 1 : 3);
    cyc = effC(cs, wr ? 0 : 1);
    useCs = wr ? cfgWrUsesCs[cs] : cfgRdUsesCs[cs];
    sCtl = useCs ? sC : sD;
    eCtl = useCs ? sC + pC : sD + pD;
    bad = (pD == 0) || (pC == 0) || (cyc < sD + pD) || (cyc < sC + pC);
    tagDir = wr ? "R2 R3 R5" : "R2 R3 R6";
    curCs = cs; curUseCs = useCs;
    reqValid = 1'b1; reqWrite = wr; reqCs = 2'(cs); reqAddr = addr; reqWdata = wd;
    @(posedge clk);
    if (bad) begin
      @(negedge clk);
      chk(reqDone && reqErr, (pD == 0 || pC == 0) ? "R10" : "R11",
          "refusal pulse", {reqDone, reqErr}, 2'b11);
      chk({memCsN, memWeN, memRdN, memDataOe} == 7'b1111110, "R10",
          "no strobe on refusal", {memCsN, memWeN, memRdN, memDataOe}, 7'b1111110);
    end else begin
      for (int k = 0; k < cyc; k++) begin
        logic [3:0] eCs;
        logic eWe, eRd, eOe, dAct, cAct;
        @(negedge clk);
        dAct = (k >= sD) && (k < sD + pD);
        cAct = (k >= sC) && (k < sC + pC);
        eCs = 4'hF; if (cAct) eCs[cs] = 1'b0;
        eWe = !(wr && dAct); eRd = !(!wr && dAct);
        eOe = wr && (k >= sCtl);
        chk({memCsN, memWeN, memRdN, reqDone} == {eCs, eWe, eRd, 1'b0}, tagDir,
            $sformatf("strobes t=%0d", k), {memCsN, memWeN, memRdN, reqDone},
            {eCs, eWe, eRd, 1'b0});
        chk(memAddr == addr, "R7", "address", memAddr, addr);
        chk(memDataOe == eOe, "R8", $sformatf("output enable t=%0d", k), memDataOe, eOe);
        if (eOe) chk(memDataOut == wd, "R8", "write data", memDataOut, wd);
      end
      @(negedge clk);
      chk(reqDone && !reqErr, "R4", "done pulse", {reqDone, reqErr}, 2'b10);
      if (!wr) chk(rspData == patt(addr), "R9",
                   $sformatf("read data end=%0d", eCtl), rspData, patt(addr));
    end
    reqValid = 1'b0;
    @(negedge clk);
    chkIdle("R1");
  endtask

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    chkIdle("R1");
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chkIdle("R1");
    end
    for (int cs = 0; cs < 4; cs++) begin
      for (int set = 0; set < 2; set++) begin
        for (int m = 0; m < 4; m++) begin
          if (set == 0)
            setCfg(cs, 6'd1, 6'd2, 6'd0, 6'd1, 7'd3, 7'd5, 7'd4, 7'd2,
                   9'd8, 9'd7, m[0], m[1]);
          else
            setCfg(cs, 6'b100010, 6'd0, 6'd3, 6'd0,
                   7'b1000001, 7'd3, 7'b1000000, 7'd10,
                   {2'b10, 7'd5}, {2'b01, 7'd10}, m[0], m[1]);
          for (int d = 0; d < 2; d++) begin
            access(cs, d == 0, 12'(12'h100 + n*37), 16'(16'h1234 + n*97));
            n++;
          end
        end
      end
    end
    // R10: zero pulse on chip select on write refuses the write, read still runs
    setCfg(1, 6'd1, 6'd2, 6'd0, 6'd1, 7'd3, 7'd0, 7'd4, 7'd2, 9'd8, 9'd7, 1'b1, 1'b0);
    access(1, 1'b1, 12'h321, 16'hBEEF);
    access(1, 1'b0, 12'h322, 16'h0);
    // R10: zero read-enable pulse refuses the read
    setCfg(2, 6'd1, 6'd2, 6'd0, 6'd1, 7'd3, 7'd5, 7'd0, 7'd2, 9'd8, 9'd7, 1'b0, 1'b0);
    access(2, 1'b0, 12'h0AA, 16'h0);
    // R11: length one short refused, exactly setup+pulse accepted
    setCfg(3, 6'd1, 6'd2, 6'd0, 6'd1, 7'd3, 7'd5, 7'd4, 7'd2, 9'd6, 9'd3, 1'b0, 1'b1);
    access(3, 1'b1, 12'h0F0, 16'h5555);
    access(3, 1'b0, 12'h0F1, 16'h0);
    setCfg(3, 6'd1, 6'd2, 6'd0, 6'd1, 7'd3, 7'd5, 7'd4, 7'd2, 9'd7, 9'd4, 1'b0, 1'b1);
    access(3, 1'b1, 12'h0F2, 16'hAAAA);
    access(3, 1'b0, 12'h0F3, 16'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule